// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block sits on the device side of a four-bank double-data-rate SDRAM model. At every rising clock edge it samples clock enable, chip select, the row strobe, the column strobe, write enable, the bank address and the address bus. From these it produces one-cycle command pulses and a record of which banks hold an open row. It also tracks whether the device is running or in one of three low-power states. The memory array, data timing and refresh counting belong to other blocks. Those blocks consume the pulses, the bank number, the auto-precharge and precharge-all flags, and the two stored mode words.

All outputs are registered. A command sampled at edge k appears on the outputs right after edge k and stays there until edge k+1. Illegal accesses still produce their command pulse. The error output also pulses, and the bank record is left unchanged.

Top module: `ddrcd_top`

## Requirements
- R1: With cke high in the running state and cs_n low, the strobe code {ras_n,cas_n,we_n} decodes to exactly one pulse in the cycle after the sampling edge: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode register load, 111 no-op. Code 110 gives no pulse. cmd_bank carries the sampled bank bits.
- R2: When cs_n is sampled high in the running state with cke high, the only output pulse is cmd_nop, whatever the strobe levels are.
- R3: Activate marks the addressed bank open. An activate to a bank that is already open pulses cmd_err and changes no bank state.
- R4: A read or write to an idle bank pulses cmd_err. A read or write with address bit 10 high, aimed at an open bank, pulses auto_pre and leaves that bank idle.
- R5: Precharge with address bit 10 low closes only the addressed bank. With bit 10 high it closes every bank and pulses pre_all.
- R6: A mode register load with ba[0]=0 stores the address bus in mode_base and pulses cmd_mrs. With ba[0]=1 it stores the bus in mode_ext and pulses cmd_emrs.
- R7: cke sampled low in the running state moves pwr_state to 1 (precharge power-down) if every bank is idle, or to 2 (active power-down) if any bank is open.
- R8: A refresh code sampled with cke low while every bank is idle moves pwr_state to 3 (self refresh) and pulses cmd_sref once. The same code with cke high pulses cmd_aref.
- R9: While pwr_state is non-zero, no command pulse is produced and bank state is held. Sampling cke high returns pwr_state to 0 with the banks unchanged, and the command at that edge is ignored.
- R10: Synchronous reset leaves all banks idle, pwr_state 0, all pulses low and both mode words zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus; bit AP_BIT is the precharge qualifier |
| cmd_act | output | 1 | Activate pulse |
| cmd_rd | output | 1 | Read pulse |
| cmd_wr | output | 1 | Write pulse |
| cmd_pre | output | 1 | Precharge pulse |
| cmd_aref | output | 1 | Auto refresh pulse |
| cmd_sref | output | 1 | Self refresh entry pulse |
| cmd_mrs | output | 1 | Base mode register load pulse |
| cmd_emrs | output | 1 | Extended mode register load pulse |
| cmd_nop | output | 1 | No-op pulse |
| cmd_bank | output | BA_W | Bank of the reported command |
| auto_pre | output | 1 | Read/write with auto-precharge |
| pre_all | output | 1 | Precharge applies to all banks |
| cmd_err | output | 1 | Illegal access for the bank state |
| mode_base | output | ADDR_W | Stored base mode word |
| mode_ext | output | ADDR_W | Stored extended mode word |
| bank_open | output | 2**BA_W | Per-bank open flag |
| pwr_state | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
The properties assume that every input is a known level at each rising edge. They also assume that reset is held from time zero until at least one edge has passed. The mask and power-down properties compare inputs and state sampled at one edge with outputs sampled at the next, so they rely on one register stage and nothing else. The bench changes inputs only on falling edges and holds one command per cycle, so each sampled command is stable and unambiguous. The bench also always returns cke high before it expects a command to be decoded.

// File: rtl/ddrcd_pkg.sv
package ddrcd_pkg;
  typedef enum logic [1:0] {
    PW_RUN  = 2'd0,
    PW_PPD  = 2'd1,
    PW_APD  = 2'd2,
    PW_SREF = 2'd3
  } pwr_t;

  typedef enum logic [2:0] {
    K_NONE, K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_MRS
  } cmd_kind_t;
endpackage

// File: rtl/ddrcd_decode.sv
module ddrcd_decode
  import ddrcd_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_t kind
);
  always_comb begin
    if (cs_n) begin
      kind = K_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  kind = K_ACT;
        3'b101:  kind = K_RD;
        3'b100:  kind = K_WR;
        3'b010:  kind = K_PRE;
        3'b001:  kind = K_REF;
        3'b000:  kind = K_MRS;
        3'b111:  kind = K_NOP;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ddrcd_power.sv
module ddrcd_power
  import ddrcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cke,
  input  cmd_kind_t kind,
  input  logic      any_open,
  output pwr_t      state,
  output logic      issue,
  output logic      sref_entry
);
  pwr_t state_d;

  assign issue      = (state == PW_RUN) && cke;
  assign sref_entry = (state == PW_RUN) && !cke && (kind == K_REF) && !any_open;

  always_comb begin
    state_d = state;
    if (state == PW_RUN) begin
      if (!cke) begin
        if (sref_entry)    state_d = PW_SREF;
        else if (any_open) state_d = PW_APD;
        else               state_d = PW_PPD;
      end
    end else if (cke) begin
      state_d = PW_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PW_RUN;
    else     state <= state_d;
  end
endmodule

// File: rtl/ddrcd_banks.sv
module ddrcd_banks
  import ddrcd_pkg::*;
#(
  parameter int BA_W  = 2,
  localparam int NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  cmd_kind_t        kind,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap,
  output logic [NBANK-1:0] open_q,
  output logic             err
);
  logic sel_open;
  logic is_acc;

  assign sel_open = open_q[ba];
  assign is_acc   = (kind == K_RD) || (kind == K_WR);
  assign err      = issue && (((kind == K_ACT) && sel_open) || (is_acc && !sel_open));

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[i] <= 1'b0;
      end else if (issue) begin
        if ((kind == K_ACT) && hit)
          open_q[i] <= 1'b1;
        else if ((kind == K_PRE) && (ap || hit))
          open_q[i] <= 1'b0;
        else if (is_acc && hit && ap)
          open_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddrcd_top.sv
module ddrcd_top
  import ddrcd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  localparam int NBANK = 1 << BA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_act,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic              cmd_pre,
  output logic              cmd_aref,
  output logic              cmd_sref,
  output logic              cmd_mrs,
  output logic              cmd_emrs,
  output logic              cmd_nop,
  output logic [BA_W-1:0]   cmd_bank,
  output logic              auto_pre,
  output logic              pre_all,
  output logic              cmd_err,
  output logic [ADDR_W-1:0] mode_base,
  output logic [ADDR_W-1:0] mode_ext,
  output logic [NBANK-1:0]  bank_open,
  output logic [1:0]        pwr_state
);
  cmd_kind_t kind;
  pwr_t      state;
  logic      issue, sref_entry, err_c, ap;

  assign ap = addr[AP_BIT];

  ddrcd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind)
  );

  ddrcd_power u_pwr (
    .clk(clk), .rst(rst), .cke(cke), .kind(kind), .any_open(|bank_open),
    .state(state), .issue(issue), .sref_entry(sref_entry)
  );

  ddrcd_banks #(.BA_W(BA_W)) u_banks (
    .clk(clk), .rst(rst), .issue(issue), .kind(kind), .ba(ba), .ap(ap),
    .open_q(bank_open), .err(err_c)
  );

  assign pwr_state = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_act   <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_pre   <= 1'b0;
      cmd_aref  <= 1'b0;
      cmd_sref  <= 1'b0;
      cmd_mrs   <= 1'b0;
      cmd_emrs  <= 1'b0;
      cmd_nop   <= 1'b0;
      cmd_bank  <= '0;
      auto_pre  <= 1'b0;
      pre_all   <= 1'b0;
      cmd_err   <= 1'b0;
      mode_base <= '0;
      mode_ext  <= '0;
    end else begin
      cmd_act  <= issue && (kind == K_ACT);
      cmd_rd   <= issue && (kind == K_RD);
      cmd_wr   <= issue && (kind == K_WR);
      cmd_pre  <= issue && (kind == K_PRE);
      cmd_aref <= issue && (kind == K_REF);
      cmd_sref <= sref_entry;
      cmd_mrs  <= issue && (kind == K_MRS) && !ba[0];
      cmd_emrs <= issue && (kind == K_MRS) && ba[0];
      cmd_nop  <= issue && (kind == K_NOP);
      cmd_bank <= ba;
      auto_pre <= issue && ap && bank_open[ba] && ((kind == K_RD) || (kind == K_WR));
      pre_all  <= issue && ap && (kind == K_PRE);
      cmd_err  <= err_c;
      if (issue && (kind == K_MRS)) begin
        if (ba[0]) mode_ext  <= addr;
        else       mode_base <= addr;
      end
    end
  end
endmodule

// File: rtl/ddrcd_checker.sv
module ddrcd_checker #(
  parameter int BA_W   = 2,
  localparam int NBANK = 1 << BA_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             cs_n,
  input logic             cmd_act,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_pre,
  input logic             cmd_aref,
  input logic             cmd_sref,
  input logic             cmd_mrs,
  input logic             cmd_emrs,
  input logic             cmd_nop,
  input logic [BA_W-1:0]  cmd_bank,
  input logic             pre_all,
  input logic             cmd_err,
  input logic [NBANK-1:0] bank_open,
  input logic [1:0]       pwr_state
);
  logic [8:0] pulses;
  assign pulses = {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref,
                   cmd_sref, cmd_mrs, cmd_emrs, cmd_nop};

  p_one_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulses));

  p_cs_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd0 && cke && cs_n) |=> (pulses == 9'b000000001));

  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_act && !cmd_err) |-> bank_open[cmd_bank]);

  p_pre_all_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_pre && pre_all) |-> (bank_open == '0));

  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd0) |=> (pulses == 9'b0));

  p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd0) |=> $stable(bank_open));
endmodule

bind ddrcd_top ddrcd_checker #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n),
  .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
  .cmd_aref(cmd_aref), .cmd_sref(cmd_sref), .cmd_mrs(cmd_mrs),
  .cmd_emrs(cmd_emrs), .cmd_nop(cmd_nop), .cmd_bank(cmd_bank),
  .pre_all(pre_all), .cmd_err(cmd_err), .bank_open(bank_open),
  .pwr_state(pwr_state)
);

// File: tb/ddrcd_top_test.sv
`timescale 1ns/1ps
module ddrcd_top_test;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [BA_W-1:0]   ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref, cmd_sref;
  logic cmd_mrs, cmd_emrs, cmd_nop, auto_pre, pre_all, cmd_err;
  logic [BA_W-1:0]   cmd_bank;
  logic [ADDR_W-1:0] mode_base, mode_ext;
  logic [3:0]        bank_open;
  logic [1:0]        pwr_state;

  always #2.5 clk = ~clk;

  ddrcd_top uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_aref(cmd_aref), .cmd_sref(cmd_sref), .cmd_mrs(cmd_mrs),
    .cmd_emrs(cmd_emrs), .cmd_nop(cmd_nop), .cmd_bank(cmd_bank),
    .auto_pre(auto_pre), .pre_all(pre_all), .cmd_err(cmd_err),
    .mode_base(mode_base), .mode_ext(mode_ext), .bank_open(bank_open),
    .pwr_state(pwr_state)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // pulse order: act rd wr pre aref sref mrs emrs nop
  localparam logic [8:0] P_0    = 9'b000000000;
  localparam logic [8:0] P_ACT  = 9'b100000000;
  localparam logic [8:0] P_RD   = 9'b010000000;
  localparam logic [8:0] P_WR   = 9'b001000000;
  localparam logic [8:0] P_PRE  = 9'b000100000;
  localparam logic [8:0] P_AREF = 9'b000010000;
  localparam logic [8:0] P_SREF = 9'b000001000;
  localparam logic [8:0] P_NOP  = 9'b000000001;

  // {req[3:0], cke, cs ras cas we, ba, a10, pulses, err, open, pwr}
  localparam int N = 24;
  localparam logic [27:0] VEC [N] = '{
    {4'd1, 1'b1, 4'b0111, 2'd0, 1'b0, P_NOP,  1'b0, 4'b0000, 2'd0}, // R1 nop
    {4'd2, 1'b1, 4'b1000, 2'd0, 1'b0, P_NOP,  1'b0, 4'b0000, 2'd0}, // R2 masked
    {4'd3, 1'b1, 4'b0011, 2'd1, 1'b0, P_ACT,  1'b0, 4'b0010, 2'd0}, // R3 act b1
    {4'd3, 1'b1, 4'b0011, 2'd1, 1'b0, P_ACT,  1'b1, 4'b0010, 2'd0}, // R3 reopen err
    {4'd4, 1'b1, 4'b0101, 2'd0, 1'b0, P_RD,   1'b1, 4'b0010, 2'd0}, // R4 rd idle
    {4'd1, 1'b1, 4'b0100, 2'd1, 1'b0, P_WR,   1'b0, 4'b0010, 2'd0}, // R1 wr
    {4'd3, 1'b1, 4'b0011, 2'd2, 1'b0, P_ACT,  1'b0, 4'b0110, 2'd0}, // R3 act b2
    {4'd4, 1'b1, 4'b0101, 2'd2, 1'b1, P_RD,   1'b0, 4'b0010, 2'd0}, // R4 autopre
    {4'd3, 1'b1, 4'b0011, 2'd3, 1'b0, P_ACT,  1'b0, 4'b1010, 2'd0}, // R3 act b3
    {4'd5, 1'b1, 4'b0010, 2'd1, 1'b0, P_PRE,  1'b0, 4'b1000, 2'd0}, // R5 pre one
    {4'd3, 1'b1, 4'b0011, 2'd0, 1'b0, P_ACT,  1'b0, 4'b1001, 2'd0}, // R3 act b0
    {4'd5, 1'b1, 4'b0010, 2'd2, 1'b1, P_PRE,  1'b0, 4'b0000, 2'd0}, // R5 pre all
    {4'd3, 1'b1, 4'b0011, 2'd0, 1'b0, P_ACT,  1'b0, 4'b0001, 2'd0}, // R3 act b0
    {4'd7, 1'b0, 4'b0111, 2'd0, 1'b0, P_0,    1'b0, 4'b0001, 2'd2}, // R7 active pd
    {4'd9, 1'b0, 4'b0011, 2'd1, 1'b0, P_0,    1'b0, 4'b0001, 2'd2}, // R9 ignored
    {4'd9, 1'b1, 4'b0011, 2'd2, 1'b0, P_0,    1'b0, 4'b0001, 2'd0}, // R9 exit
    {4'd5, 1'b1, 4'b0010, 2'd0, 1'b1, P_PRE,  1'b0, 4'b0000, 2'd0}, // R5 pre all
    {4'd7, 1'b0, 4'b0111, 2'd0, 1'b0, P_0,    1'b0, 4'b0000, 2'd1}, // R7 precharge pd
    {4'd9, 1'b1, 4'b0111, 2'd0, 1'b0, P_0,    1'b0, 4'b0000, 2'd0}, // R9 exit
    {4'd8, 1'b1, 4'b0001, 2'd0, 1'b0, P_AREF, 1'b0, 4'b0000, 2'd0}, // R8 aref
    {4'd8, 1'b0, 4'b0001, 2'd0, 1'b0, P_SREF, 1'b0, 4'b0000, 2'd3}, // R8 sref
    {4'd9, 1'b0, 4'b0111, 2'd0, 1'b0, P_0,    1'b0, 4'b0000, 2'd3}, // R9 stay
    {4'd9, 1'b1, 4'b0111, 2'd0, 1'b0, P_0,    1'b0, 4'b0000, 2'd0}, // R9 exit
    {4'd1, 1'b1, 4'b0111, 2'd0, 1'b0, P_NOP,  1'b0, 4'b0000, 2'd0}  // R1 nop
  };

  function automatic logic [8:0] pulses();
    return {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref,
            cmd_sref, cmd_mrs, cmd_emrs, cmd_nop};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] c,
                       input logic [BA_W-1:0] b, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 pulses", 32'(pulses()), 32'(P_0));
    chk("R10 open", 32'(bank_open), 32'h0);
    chk("R10 pwr", 32'(pwr_state), 32'h0);
    chk("R10 mode", 32'({mode_base, mode_ext}), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      logic [27:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[27:24], i);
      drive(v[23], v[22:19], v[18:17], {2'b00, v[16], 10'h155});
      chk({tag, " pulses"}, 32'(pulses()), 32'(v[15:7]));
      chk({tag, " err"}, 32'(cmd_err), 32'(v[6]));
      chk({tag, " open"}, 32'(bank_open), 32'(v[5:2]));
      chk({tag, " pwr"}, 32'(pwr_state), 32'(v[1:0]));
    end

    // R6 mode register loads, selected by ba[0]
    drive(1'b1, 4'b0000, 2'd0, 13'h0123);
    chk("R6 mrs pulse", 32'(pulses()), 32'(9'b000000100));
    chk("R6 base word", 32'(mode_base), 32'h0123);
    chk("R6 ext untouched", 32'(mode_ext), 32'h0);
    drive(1'b1, 4'b0000, 2'd1, 13'h1042);
    chk("R6 emrs pulse", 32'(pulses()), 32'(9'b000000010));
    chk("R6 ext word", 32'(mode_ext), 32'h1042);
    chk("R6 base kept", 32'(mode_base), 32'h0123);

    // R1 bank number and the unused strobe code
    drive(1'b1, 4'b0011, 2'd3, 13'h0);
    chk("R1 bank out", 32'(cmd_bank), 32'd3);
    drive(1'b1, 4'b0110, 2'd3, 13'h0);
    chk("R1 code 110", 32'(pulses()), 32'(P_0));

    // R4 write with auto-precharge flag
    drive(1'b1, 4'b0100, 2'd3, 13'h0400);
    chk("R4 auto_pre", 32'(auto_pre), 32'h1);
    chk("R4 closed", 32'(bank_open), 32'h0);

    // R5 pre_all flag with a single-bank precharge
    drive(1'b1, 4'b0011, 2'd2, 13'h0);
    drive(1'b1, 4'b0010, 2'd2, 13'h0);
    chk("R5 single flag", 32'(pre_all), 32'h0);

    // R8 refresh with cke low and a bank open gives active power-down
    drive(1'b1, 4'b0011, 2'd1, 13'h0);
    drive(1'b0, 4'b0001, 2'd0, 13'h0);
    chk("R8 no sref open", 32'(pulses()), 32'(P_0));
    chk("R8 pwr apd", 32'(pwr_state), 32'd2);
    drive(1'b1, 4'b0111, 2'd0, 13'h0);

    // R10 reset mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 open cleared", 32'(bank_open), 32'h0);
    chk("R10 mode cleared", 32'(mode_base), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    finish_run();
  end
endmodule